// File: doc/BRIEF.md
# Dual-Slot Power Protection Sequencer

This block is the digital control core for two independent power slots. Each slot has a main output enable, which covers the +12V and +3.3V rails, and an auxiliary output enable. The block samples digitized status flags for each slot and one global flag. It decides each clock whether the slot's outputs may stay on, and it drives an active-low power-good and an active-low fault output per slot.

Protection is split into two thermal tiers. A slot overtemperature flag that is raised while that slot is in slow overcurrent shuts only that slot. The global die overtemperature flag shuts both slots and sets a sticky status bit, which a write-one-to-clear strobe clears. Overcurrent and rail undervoltage trips latch a shutdown. The latch holds until both of the slot's requests are dropped and then raised again.

An active-low force-on pin per slot turns on all outputs and ignores every protection. The one exception is standby undervoltage. A register bit can mask the force-on pin. The auxiliary request is honoured only after a power-on wait, which runs from the moment standby becomes valid.

Top module: `dual_slot_pwr_seq`

## Requirements
- R1: During reset all main and auxiliary enables are 0, pgoodN and faultN are all 1, and dieHotSticky is 0.
- R2: With standby valid and no latched shutdown, raising onReq[s] sets mainEn[s] at the next clock edge.
- R3: auxReq[s] is ignored until standby of slot s has been valid for POR_CYCLES clock edges. Standby undervoltage (uvStby[s]=1) turns both enables of slot s off at the next edge without latching a fault, and restarts the wait.
- R4: pgoodN[s] is 0 exactly when mainEn[s] and auxEn[s] are both 1, the 12 V and 3.3 V undervoltage flags are clear, and force-on is not active.
- R5: When slot s is requested (onReq[s] or auxReq[s]) and ocFast[s], uv12[s] or uv3[s] is 1, both enables of s go to 0 and faultN[s] goes to 0 at the next edge.
- R6: A slow overcurrent (ocSlow[s]=1) shuts slot s only after it has been held for slowLimit consecutive edges.
- R7: slotHot[s] together with ocSlow[s] shuts slot s at the next edge and leaves the other slot running. slotHot[s] alone has no effect.
- R8: dieHot shuts every requested slot at the next edge and sets dieHotSticky. dieHotSticky stays 1 until otClr is 1 at an edge.
- R9: A shutdown of slot s stays latched until onReq[s] and auxReq[s] are both 0 at an edge. Raising them again then powers the slot.
- R10: While forceOnN[s]=0 and forceMask[s]=0, both enables of s are 1 and pgoodN[s] and faultN[s] are 1, whatever the overcurrent, thermal and rail undervoltage flags are.
- R11: Force-on does not override standby undervoltage: with uvStby[s]=1 both enables of s are 0.
- R12: With forceMask[s]=1, forceOnN[s] has no effect on slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvStby | input | NSLOT | Standby supply below threshold, per slot |
| uv12 | input | NSLOT | 12 V supply below threshold, per slot |
| uv3 | input | NSLOT | 3.3 V supply below threshold, per slot |
| ocFast | input | NSLOT | Fast overcurrent trip, per slot |
| ocSlow | input | NSLOT | Slow overcurrent (current limiting), per slot |
| slotHot | input | NSLOT | Slot overtemperature, per slot |
| dieHot | input | 1 | Global die overtemperature |
| onReq | input | NSLOT | Main power request, per slot |
| auxReq | input | NSLOT | Auxiliary power request, per slot |
| forceOnN | input | NSLOT | Active-low force-on pin, per slot |
| forceMask | input | NSLOT | Register bit that masks force-on, per slot |
| slowLimit | input | FILT_W | Slow overcurrent filter length in cycles |
| otClr | input | 1 | Clears dieHotSticky (write-one strobe) |
| mainEn | output | NSLOT | Main (+12V/+3.3V) enable, per slot |
| auxEn | output | NSLOT | Auxiliary enable, per slot |
| pgoodN | output | NSLOT | Active-low power-good, per slot |
| faultN | output | NSLOT | Active-low fault, per slot |
| dieHotSticky | output | 1 | Sticky global overtemperature status |

## Verification
Every output is a register fed from the inputs and the latch state. Enables, power-good and fault therefore respond one edge after a flag or request changes, and the bench checks them after exactly one rising edge. The two counted windows are checked on both sides. For the slow filter, the bench checks that the slot is still on two edges before slowLimit and off one edge after it. For the power-on wait, the auxiliary enable is checked off early in the window and on once POR_CYCLES edges of valid standby have passed. Inputs change on the falling edge and outputs are read on a falling edge, so no result depends on the order of events at the rising edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // Strobes from the slot control logic to the counter datapath
  typedef struct packed {
    logic porHold;  // standby invalid: hold the power-on counter at zero
    logic filtRun;  // slow overcurrent present and honoured: run filter
  } slotStrobe_t;
endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int NSLOT      = 2,
  parameter int POR_CYCLES = 25000,
  parameter int FILT_W     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  slotStrobe_t [NSLOT-1:0] strobe,
  input  logic [FILT_W-1:0]       slowLimit,
  input  logic                    dieHot,
  input  logic                    otClr,
  output logic [NSLOT-1:0]        porDone,
  output logic [NSLOT-1:0]        slowExp,
  output logic                    dieHotSticky
);
  localparam int POR_W = $clog2(POR_CYCLES + 1);
  localparam logic [POR_W-1:0]  POR_MAX  = POR_W'(POR_CYCLES);
  localparam logic [FILT_W-1:0] FILT_SAT = '1;

  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    logic [POR_W-1:0]  porCnt;
    logic [FILT_W-1:0] slowCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        porCnt <= '0;
      end else if (strobe[s].porHold) begin
        porCnt <= '0;
      end else if (porCnt != POR_MAX) begin
        porCnt <= porCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slowCnt <= '0;
      end else if (!strobe[s].filtRun) begin
        slowCnt <= '0;
      end else if (slowCnt != FILT_SAT) begin
        slowCnt <= slowCnt + 1'b1;
      end
    end

    assign porDone[s] = (porCnt == POR_MAX);
    assign slowExp[s] = strobe[s].filtRun && (slowCnt >= slowLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dieHotSticky <= 1'b0;
    end else if (dieHot) begin
      dieHotSticky <= 1'b1;
    end else if (otClr) begin
      dieHotSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NSLOT-1:0]        uvStby,
  input  logic [NSLOT-1:0]        uv12,
  input  logic [NSLOT-1:0]        uv3,
  input  logic [NSLOT-1:0]        ocFast,
  input  logic [NSLOT-1:0]        ocSlow,
  input  logic [NSLOT-1:0]        slotHot,
  input  logic                    dieHot,
  input  logic [NSLOT-1:0]        onReq,
  input  logic [NSLOT-1:0]        auxReq,
  input  logic [NSLOT-1:0]        forceOnN,
  input  logic [NSLOT-1:0]        forceMask,
  input  logic [NSLOT-1:0]        porDone,
  input  logic [NSLOT-1:0]        slowExp,
  output slotStrobe_t [NSLOT-1:0] strobe,
  output logic [NSLOT-1:0]        mainEn,
  output logic [NSLOT-1:0]        auxEn,
  output logic [NSLOT-1:0]        pgoodN,
  output logic [NSLOT-1:0]        faultN
);
  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    logic forceAct, forceOk, enReq, trip;
    logic latched, latchNxt, mainNxt, auxNxt, pgNxt, faultNxt;

    always_comb begin
      forceAct = !forceOnN[s] && !forceMask[s];
      forceOk  = forceAct && !uvStby[s];
      enReq    = onReq[s] || auxReq[s];
      trip     = !forceAct && enReq &&
                 (ocFast[s] || uv12[s] || uv3[s] || dieHot ||
                  (ocSlow[s] && slowExp[s]) ||
                  (ocSlow[s] && slotHot[s]));
      latchNxt = enReq ? (latched || trip) : 1'b0;
      mainNxt  = forceOk ||
                 (!forceAct && onReq[s] && !latchNxt && !uvStby[s]);
      auxNxt   = forceOk ||
                 (!forceAct && auxReq[s] && porDone[s] && !latchNxt && !uvStby[s]);
      pgNxt    = !forceAct && mainNxt && auxNxt && !uv12[s] && !uv3[s];
      faultNxt = !forceAct && latchNxt;
      strobe[s].porHold = uvStby[s];
      strobe[s].filtRun = ocSlow[s] && !forceAct;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latched   <= 1'b0;
        mainEn[s] <= 1'b0;
        auxEn[s]  <= 1'b0;
        pgoodN[s] <= 1'b1;
        faultN[s] <= 1'b1;
      end else begin
        latched   <= latchNxt;
        mainEn[s] <= mainNxt;
        auxEn[s]  <= auxNxt;
        pgoodN[s] <= !pgNxt;
        faultN[s] <= !faultNxt;
      end
    end
  end
endmodule

// File: rtl/dual_slot_pwr_seq.sv
module dual_slot_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int NSLOT      = 2,
  parameter int POR_CYCLES = 25000,
  parameter int FILT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSLOT-1:0]  uvStby,
  input  logic [NSLOT-1:0]  uv12,
  input  logic [NSLOT-1:0]  uv3,
  input  logic [NSLOT-1:0]  ocFast,
  input  logic [NSLOT-1:0]  ocSlow,
  input  logic [NSLOT-1:0]  slotHot,
  input  logic              dieHot,
  input  logic [NSLOT-1:0]  onReq,
  input  logic [NSLOT-1:0]  auxReq,
  input  logic [NSLOT-1:0]  forceOnN,
  input  logic [NSLOT-1:0]  forceMask,
  input  logic [FILT_W-1:0] slowLimit,
  input  logic              otClr,
  output logic [NSLOT-1:0]  mainEn,
  output logic [NSLOT-1:0]  auxEn,
  output logic [NSLOT-1:0]  pgoodN,
  output logic [NSLOT-1:0]  faultN,
  output logic              dieHotSticky
);
  slotStrobe_t [NSLOT-1:0] strobe;
  logic [NSLOT-1:0]        porDone;
  logic [NSLOT-1:0]        slowExp;

  pwr_seq_ctrl #(.NSLOT(NSLOT)) ctrl (
    .clk(clk), .rstN(rstN), .uvStby(uvStby), .uv12(uv12), .uv3(uv3),
    .ocFast(ocFast), .ocSlow(ocSlow), .slotHot(slotHot), .dieHot(dieHot),
    .onReq(onReq), .auxReq(auxReq), .forceOnN(forceOnN),
    .forceMask(forceMask), .porDone(porDone), .slowExp(slowExp),
    .strobe(strobe), .mainEn(mainEn), .auxEn(auxEn), .pgoodN(pgoodN),
    .faultN(faultN)
  );

  pwr_seq_dp #(.NSLOT(NSLOT), .POR_CYCLES(POR_CYCLES), .FILT_W(FILT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slowLimit(slowLimit),
    .dieHot(dieHot), .otClr(otClr), .porDone(porDone), .slowExp(slowExp),
    .dieHotSticky(dieHotSticky)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [NSLOT-1:0] uvStby,
  input logic [NSLOT-1:0] ocFast,
  input logic             dieHot,
  input logic [NSLOT-1:0] onReq,
  input logic [NSLOT-1:0] auxReq,
  input logic [NSLOT-1:0] forceOnN,
  input logic [NSLOT-1:0] forceMask,
  input logic [NSLOT-1:0] mainEn,
  input logic [NSLOT-1:0] auxEn,
  input logic [NSLOT-1:0] pgoodN,
  input logic [NSLOT-1:0] faultN,
  input logic             dieHotSticky
);
  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    // R5
    fast_trip_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ocFast[s] && (onReq[s] || auxReq[s]) && !(!forceOnN[s] && !forceMask[s]))
      |=> (!mainEn[s] && !auxEn[s] && !faultN[s]));

    // R8
    die_hot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dieHot && !(!forceOnN[s] && !forceMask[s]))
      |=> (!mainEn[s] && !auxEn[s]));

    // R10
    force_on_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!forceOnN[s] && !forceMask[s] && !uvStby[s])
      |=> (mainEn[s] && auxEn[s] && pgoodN[s] && faultN[s]));

    // R11
    stby_lockout_chk: assert property (@(posedge clk) disable iff (!rstN)
      uvStby[s] |=> (!mainEn[s] && !auxEn[s]));
  end

  // R8
  die_hot_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dieHot |=> dieHotSticky);
endmodule

bind dual_slot_pwr_seq pwr_seq_chk #(.NSLOT(NSLOT)) chk (
  .clk(clk), .rstN(rstN), .uvStby(uvStby), .ocFast(ocFast), .dieHot(dieHot),
  .onReq(onReq), .auxReq(auxReq), .forceOnN(forceOnN), .forceMask(forceMask),
  .mainEn(mainEn), .auxEn(auxEn), .pgoodN(pgoodN), .faultN(faultN),
  .dieHotSticky(dieHotSticky)
);

// File: tb/dual_slot_pwr_seq_test.sv
module dual_slot_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 2;
  localparam int POR        = 16;
  localparam int FILT_W     = 8;
  localparam int FILT_LEN   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSLOT-1:0]  uvStby = '0, uv12 = '0, uv3 = '0, ocFast = '0;
  logic [NSLOT-1:0]  ocSlow = '0, slotHot = '0, onReq = '0, auxReq = '0;
  logic [NSLOT-1:0]  forceOnN = '1, forceMask = '0;
  logic              dieHot = 1'b0, otClr = 1'b0;
  logic [FILT_W-1:0] slowLimit = FILT_W'(FILT_LEN);
  logic [NSLOT-1:0]  mainEn, auxEn, pgoodN, faultN;
  logic              dieHotSticky;

  int totalCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_slot_pwr_seq #(.NSLOT(NSLOT), .POR_CYCLES(POR), .FILT_W(FILT_W)) uut (
    .clk(clk), .rstN(rstN), .uvStby(uvStby), .uv12(uv12), .uv3(uv3),
    .ocFast(ocFast), .ocSlow(ocSlow), .slotHot(slotHot), .dieHot(dieHot),
    .onReq(onReq), .auxReq(auxReq), .forceOnN(forceOnN),
    .forceMask(forceMask), .slowLimit(slowLimit), .otClr(otClr),
    .mainEn(mainEn), .auxEn(auxEn), .pgoodN(pgoodN), .faultN(faultN),
    .dieHotSticky(dieHotSticky)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drop both requests of a slot for one edge, then raise them again
  task automatic rearm(input int s);
    onReq[s] = 1'b0; auxReq[s] = 1'b0;
    step(1);
    onReq[s] = 1'b1; auxReq[s] = 1'b1;
    step(1);
  endtask

  task automatic tReset;
    step(3);
    check("R1 mainEn", 32'(mainEn), 0);
    check("R1 auxEn", 32'(auxEn), 0);
    check("R1 pgoodN", 32'(pgoodN), 3);
    check("R1 faultN", 32'(faultN), 3);
    check("R1 sticky", 32'(dieHotSticky), 0);
    rstN = 1'b1;
  endtask

  task automatic tPowerUp;
    onReq = 2'b11; auxReq = 2'b11;
    step(1);
    check("R2 main on", 32'(mainEn), 3);
    check("R3 aux waits", 32'(auxEn), 0);
    check("R4 pgood off", 32'(pgoodN), 3);
    step(POR);
    check("R3 aux after wait", 32'(auxEn), 3);
    check("R4 pgood on", 32'(pgoodN), 0);
    check("R4 fault idle", 32'(faultN), 3);
  endtask

  task automatic tFastTrip;
    ocFast[0] = 1'b1;
    step(1);
    check("R5 fast main", 32'(mainEn), 2);
    check("R5 fast aux", 32'(auxEn), 2);
    check("R5 fast fault", 32'(faultN), 2);
    ocFast[0] = 1'b0;
    step(2);
    check("R9 stays latched", 32'(mainEn), 2);
    onReq[0] = 1'b0; auxReq[0] = 1'b0;
    step(1);
    check("R9 fault cleared", 32'(faultN), 3);
    onReq[0] = 1'b1; auxReq[0] = 1'b1;
    step(1);
    check("R9 repowered main", 32'(mainEn), 3);
    check("R9 repowered aux", 32'(auxEn), 3);
  endtask

  task automatic tRailUv;
    uv3[1] = 1'b1;
    step(1);
    check("R5 uv3 main", 32'(mainEn), 1);
    check("R5 uv3 fault", 32'(faultN), 1);
    uv3[1] = 1'b0;
    rearm(1);
    uv12[0] = 1'b1;
    step(1);
    check("R5 uv12 main", 32'(mainEn), 2);
    uv12[0] = 1'b0;
    rearm(0);
    check("R9 both back", 32'(mainEn), 3);
  endtask

  task automatic tSlowFilter;
    ocSlow[1] = 1'b1;
    step(FILT_LEN - 2);
    check("R6 still on", 32'(mainEn), 3);
    step(3);
    check("R6 filter expired", 32'(mainEn), 1);
    check("R6 fault", 32'(faultN), 1);
    ocSlow[1] = 1'b0;
    rearm(1);
  endtask

  task automatic tSlotHot;
    slotHot[1] = 1'b1;
    step(3);
    check("R7 hot alone ignored", 32'(mainEn), 3);
    slotHot[1] = 1'b0;
    ocSlow[0] = 1'b1; slotHot[0] = 1'b1;
    step(1);
    check("R7 hot slot off", 32'(mainEn), 2);
    check("R7 other aux on", 32'(auxEn), 2);
    check("R7 fault slot", 32'(faultN), 2);
    ocSlow[0] = 1'b0; slotHot[0] = 1'b0;
    rearm(0);
  endtask

  task automatic tDieHot;
    dieHot = 1'b1;
    step(1);
    check("R8 both main off", 32'(mainEn), 0);
    check("R8 both aux off", 32'(auxEn), 0);
    check("R8 both fault", 32'(faultN), 0);
    check("R8 sticky set", 32'(dieHotSticky), 1);
    dieHot = 1'b0;
    step(2);
    check("R8 sticky holds", 32'(dieHotSticky), 1);
    otClr = 1'b1;
    step(1);
    check("R8 sticky cleared", 32'(dieHotSticky), 0);
    otClr = 1'b0;
  endtask

  task automatic tForce;
    onReq = '0; auxReq = '0;
    step(1);
    check("R9 idle off", 32'(mainEn), 0);
    forceOnN[0] = 1'b0; ocFast[0] = 1'b1; dieHot = 1'b1;
    step(1);
    check("R10 force main", 32'(mainEn), 1);
    check("R10 force aux", 32'(auxEn), 1);
    check("R10 force pgoodN", 32'(pgoodN), 3);
    check("R10 force faultN", 32'(faultN), 3);
    uvStby[0] = 1'b1;
    step(1);
    check("R11 stby beats force", 32'(mainEn), 0);
    check("R11 stby aux", 32'(auxEn), 0);
    uvStby[0] = 1'b0; ocFast[0] = 1'b0; dieHot = 1'b0;
    forceMask[0] = 1'b1;
    step(1);
    check("R12 masked main", 32'(mainEn), 0);
    check("R12 masked aux", 32'(auxEn), 0);
    forceMask[0] = 1'b0; forceOnN[0] = 1'b1;
    otClr = 1'b1;
    step(1);
    otClr = 1'b0;
  endtask

  task automatic tStby;
    onReq = 2'b11; auxReq = 2'b11;
    step(POR + 2);
    check("R3 both powered", 32'(auxEn), 3);
    uvStby[1] = 1'b1;
    step(1);
    check("R3 stby off main", 32'(mainEn), 1);
    check("R3 stby no fault", 32'(faultN), 3);
    uvStby[1] = 1'b0;
    step(2);
    check("R3 main back", 32'(mainEn), 3);
    check("R3 wait restarted", 32'(auxEn), 1);
    step(POR);
    check("R3 aux after restart", 32'(auxEn), 3);
  endtask

  initial begin
    tReset();
    tPowerUp();
    tFastTrip();
    tRailUv();
    tSlowFilter();
    tSlotHot();
    tDieHot();
    tForce();
    tStby();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule